// File: doc/BRIEF.md
# Key-Controlled Storage Protection Unit

This unit decides whether each access to real storage may proceed. Storage is divided into 2 KiB blocks, and every block has a small entry in an on-chip array. The entry holds a 4-bit protection key, a fetch-protect flag, a referenced flag and a changed flag. An access request carries an address, a direction (fetch or store) and the requester's 4-bit key. The unit answers with either a grant or a protection violation. A granted access also updates the block's referenced and changed flags.

Two privileged commands act on the array directly. The set-key command overwrites a block's whole entry. The insert-key command returns the entry. A separate low-address protection input, when it is active, blocks stores to the first 512 bytes whatever key the requester holds.

The unit is a four-state machine: `S_CLEAR`, `S_IDLE`, `S_CHECK` and `S_RESP`.
- `S_CLEAR` is entered at reset. It walks the array and writes every entry to zero, then moves to `S_IDLE` after the last index.
- `S_IDLE` raises `req_ready`. When a request is accepted it moves to `S_CHECK`.
- `S_CHECK` reads the entry, judges the request and writes any update. It always moves to `S_RESP`.
- `S_RESP` shows the response for one cycle and always returns to `S_IDLE`.

Top module: `keyprot_unit`

## Requirements
- R1: After reset `req_ready` stays low while `S_CLEAR` zeroes all entries. From then on, every entry reads back as zero until it is written.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. `rsp_valid` is high for exactly one cycle, two edges after acceptance. `req_ready` is low from acceptance until that response is over.
- R3: `req_op` encodes the operation as 0 = fetch, 1 = store, 2 = set-key, 3 = insert-key. For insert-key, `rsp_data` returns the entry as it stood before the command. For every other operation `rsp_data` is zero.
- R4: Set-key is always granted and writes `req_data` as the whole entry, including the referenced and changed flags.
- R5: The entry layout in `req_data` and `rsp_data` is: bits 6:3 key, bit 2 fetch-protect, bit 1 referenced, bit 0 changed.
- R6: A store whose requester key differs from the block key is a violation.
- R7: A fetch is a violation only if the block's fetch-protect flag is set and the keys differ. With the flag clear, a fetch is granted whatever the key.
- R8: A requester key of zero matches every block key.
- R9: A granted fetch sets the referenced flag. A granted store sets both the referenced and the changed flag.
- R10: A violating access leaves the entry unchanged.
- R11: With `lap_en` high at acceptance, a store to an address below 512 is a violation even with key zero. Address 512 is unaffected, and so are fetches.
- R12: The block index is the address shifted right by 11, up to the highest block.
- R13: Every response has exactly one of `rsp_grant` and `rsp_viol` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request (state `S_IDLE`) |
| req_op | input | 2 | Operation code (see R3) |
| req_addr | input | ADDR_W (20) | Real byte address |
| req_key | input | 4 | Requester access key |
| req_data | input | 7 | Entry value for set-key (layout in R5) |
| lap_en | input | 1 | Low-address store protection enable |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_grant | output | 1 | Request granted |
| rsp_viol | output | 1 | Protection violation |
| rsp_data | output | 7 | Entry returned by insert-key |

## Verification
The hardest behaviour to observe is the absence of a side effect. When an access violates, the referenced and changed flags must stay as they were, and those flags are visible only through a later insert-key command. The stimulus therefore follows each violating access, and each grant that should touch the flags, with an insert-key command to the same block.

Low-address protection is tested at its edge: stores at addresses 511 and 512 with the master key, with `lap_en` on and off. A fetch-protected block is driven with a mismatching key, a matching key and key zero.

// File: rtl/keyprot_pkg.sv
package keyprot_pkg;

    typedef struct packed {
        logic [3:0] key;
        logic       fetch_prot;
        logic       referenced;
        logic       changed;
    } blk_entry_t;

    localparam int ENTRY_W = $bits(blk_entry_t);

    typedef enum logic [1:0] {
        OP_FETCH  = 2'd0,
        OP_STORE  = 2'd1,
        OP_SETKEY = 2'd2,
        OP_INSKEY = 2'd3
    } prot_op_t;

    typedef enum logic [1:0] {
        S_CLEAR,
        S_IDLE,
        S_CHECK,
        S_RESP
    } prot_state_t;

endpackage

// File: rtl/key_array.sv
module key_array
    import keyprot_pkg::*;
#(
    parameter int IDX_W = 9,
    localparam int NBLK = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  blk_entry_t       wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output blk_entry_t       rd_data
);

    blk_entry_t mem [NBLK];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem[rd_idx];

endmodule

// File: rtl/access_judge.sv
module access_judge
    import keyprot_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int LOW_LIMIT = 512
) (
    input  prot_op_t          op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        req_key,
    input  logic              lap_en,
    input  blk_entry_t        set_val,
    input  blk_entry_t        cur,
    output logic              grant,
    output logic              viol,
    output logic              upd_en,
    output blk_entry_t        upd_val,
    output blk_entry_t        out_val
);

    logic key_match;
    logic low_zone;

    assign key_match = (req_key == 4'd0) || (req_key == cur.key);
    assign low_zone  = lap_en && (addr < ADDR_W'(LOW_LIMIT));

    always_comb begin
        viol    = 1'b0;
        upd_val = cur;
        out_val = '0;
        unique case (op)
            OP_FETCH: begin
                viol               = cur.fetch_prot && !key_match;
                upd_val.referenced = 1'b1;
            end
            OP_STORE: begin
                viol               = !key_match || low_zone;
                upd_val.referenced = 1'b1;
                upd_val.changed    = 1'b1;
            end
            OP_SETKEY: begin
                upd_val = set_val;
            end
            OP_INSKEY: begin
                out_val = cur;
            end
        endcase
        grant  = !viol;
        upd_en = grant && (op != OP_INSKEY);
    end

endmodule

// File: rtl/keyprot_unit.sv
module keyprot_unit
    import keyprot_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int BLK_SHIFT = 11,
    parameter int LOW_LIMIT = 512,
    localparam int IDX_W    = ADDR_W - BLK_SHIFT
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [1:0]          req_op,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [3:0]          req_key,
    input  logic [ENTRY_W-1:0]  req_data,
    input  logic                lap_en,
    output logic                rsp_valid,
    output logic                rsp_grant,
    output logic                rsp_viol,
    output logic [ENTRY_W-1:0]  rsp_data
);

    prot_state_t       state_q, state_d;
    logic [IDX_W-1:0]  clr_idx_q;
    prot_op_t          op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [3:0]        key_q;
    blk_entry_t        data_q;
    logic              lap_q;

    logic              arr_wr_en;
    logic [IDX_W-1:0]  arr_wr_idx;
    blk_entry_t        arr_wr_data;
    blk_entry_t        rd_entry;
    logic [IDX_W-1:0]  blk_idx;

    logic              j_grant, j_viol, j_upd;
    blk_entry_t        j_upd_val, j_out_val;

    assign blk_idx   = addr_q[ADDR_W-1:BLK_SHIFT];
    assign req_ready = (state_q == S_IDLE);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_CLEAR: if (&clr_idx_q) state_d = S_IDLE;
            S_IDLE:  if (req_valid)  state_d = S_CHECK;
            S_CHECK: state_d = S_RESP;
            S_RESP:  state_d = S_IDLE;
        endcase
    end

    // array write port: zero walk during clear, update during check
    always_comb begin
        arr_wr_en   = 1'b0;
        arr_wr_idx  = blk_idx;
        arr_wr_data = j_upd_val;
        if (state_q == S_CLEAR) begin
            arr_wr_en   = 1'b1;
            arr_wr_idx  = clr_idx_q;
            arr_wr_data = '0;
        end else if (state_q == S_CHECK) begin
            arr_wr_en   = j_upd;
        end
    end

    key_array #(.IDX_W(IDX_W)) i_key_array (
        .clk     (clk),
        .wr_en   (arr_wr_en),
        .wr_idx  (arr_wr_idx),
        .wr_data (arr_wr_data),
        .rd_idx  (blk_idx),
        .rd_data (rd_entry)
    );

    access_judge #(.ADDR_W(ADDR_W), .LOW_LIMIT(LOW_LIMIT)) i_access_judge (
        .op      (op_q),
        .addr    (addr_q),
        .req_key (key_q),
        .lap_en  (lap_q),
        .set_val (data_q),
        .cur     (rd_entry),
        .grant   (j_grant),
        .viol    (j_viol),
        .upd_en  (j_upd),
        .upd_val (j_upd_val),
        .out_val (j_out_val)
    );

    // outputs, request capture and clear counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_idx_q <= '0;
            op_q      <= OP_FETCH;
            addr_q    <= '0;
            key_q     <= '0;
            data_q    <= '0;
            lap_q     <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_grant <= 1'b0;
            rsp_viol  <= 1'b0;
            rsp_data  <= '0;
        end else begin
            if (state_q == S_CLEAR) clr_idx_q <= clr_idx_q + 1'b1;
            if (state_q == S_IDLE && req_valid) begin
                op_q   <= prot_op_t'(req_op);
                addr_q <= req_addr;
                key_q  <= req_key;
                data_q <= blk_entry_t'(req_data);
                lap_q  <= lap_en;
            end
            rsp_valid <= (state_q == S_CHECK);
            rsp_grant <= (state_q == S_CHECK) && j_grant;
            rsp_viol  <= (state_q == S_CHECK) && j_viol;
            rsp_data  <= (state_q == S_CHECK) ? j_out_val : '0;
        end
    end

    // R13
    resp_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_grant ^ rsp_viol));

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R2
    resp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> ##2 rsp_valid);

    // R2
    resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R11
    low_store_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CHECK && op_q == OP_STORE && lap_q &&
         addr_q < ADDR_W'(LOW_LIMIT)) |=> rsp_viol);

    // R7
    fetch_unprot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CHECK && op_q == OP_FETCH && !rd_entry.fetch_prot) |=> rsp_grant);

    // R8
    master_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CHECK && op_q == OP_FETCH && key_q == 4'd0) |=> rsp_grant);

    // R10
    viol_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CHECK && rsp_viol == 1'b0 && j_viol) |-> !arr_wr_en);

endmodule

// File: tb/test_keyprot_unit.sv
module test_keyprot_unit;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic       g;
        logic       v;
        logic [6:0] d;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = '0;
    logic [19:0] req_addr = '0;
    logic [3:0]  req_key = '0;
    logic [6:0]  req_data = '0;
    logic        lap_en = 1'b0;
    logic        rsp_valid, rsp_grant, rsp_viol;
    logic [6:0]  rsp_data;

    int checks = 0;
    int errors = 0;
    exp_t sb[$];
    logic [6:0] model [512];

    always #(CLK_PERIOD/2) clk = ~clk;

    keyprot_unit i_keyprot_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_key(req_key), .req_data(req_data),
        .lap_en(lap_en), .rsp_valid(rsp_valid), .rsp_grant(rsp_grant),
        .rsp_viol(rsp_viol), .rsp_data(rsp_data)
    );

    task automatic check(input string tag, input logic [6:0] act, input logic [6:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: compute expectation from the requirements, push it, drive the request
    task automatic issue(input logic [1:0] op, input logic [19:0] addr, input logic [3:0] key,
                         input logic [6:0] sd, input logic lap, input string tag);
        exp_t e;
        logic [8:0] idx;
        logic [6:0] ent;
        logic match, low;
        idx   = addr[19:11];
        ent   = model[idx];
        match = (key == 4'd0) || (key == ent[6:3]);
        low   = lap && (addr < 20'd512);
        e.v   = 1'b0;
        e.d   = '0;
        e.tag = tag;
        case (op)
            2'd0: begin e.v = ent[2] && !match; if (!e.v) model[idx][1] = 1'b1; end
            2'd1: begin e.v = !match || low;    if (!e.v) model[idx][1:0] = 2'b11; end
            2'd2: model[idx] = sd;
            default: e.d = ent;
        endcase
        e.g = !e.v;
        sb.push_back(e);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = addr; req_key = key;
        req_data = sd; lap_en = lap;
        @(negedge clk);
        req_valid = 1'b0;
        check({"R2 busy after accept ", tag}, {6'd0, req_ready}, 7'd0);
        check({"R2 no early response ", tag}, {6'd0, rsp_valid}, 7'd0);
    endtask

    // monitor: pop and compare each response
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb.size() == 0) begin
                checks++; errors++;
                $display("FAIL R2 unexpected response actual=1 expected=0");
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({"R13 grant ", e.tag}, {6'd0, rsp_grant}, {6'd0, e.g});
                check({"viol ", e.tag}, {6'd0, rsp_viol}, {6'd0, e.v});
                check({"R3 data ", e.tag}, rsp_data, e.d);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 512; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready low during clear", {6'd0, req_ready}, 7'd0);
        check("R1 no response after reset", {6'd0, rsp_valid}, 7'd0);

        issue(2'd3, 20'h02800, 4'd0, 7'h00, 1'b0, "R1 cleared entry blk5");
        issue(2'd2, 20'h02800, 4'd9, 7'h18, 1'b0, "R4 setkey blk5 key3");
        issue(2'd3, 20'h02A00, 4'd0, 7'h00, 1'b0, "R5 inskey blk5 layout");
        issue(2'd0, 20'h02810, 4'd7, 7'h00, 1'b0, "R7 fetch unprotected mismatch");
        issue(2'd3, 20'h02800, 4'd0, 7'h00, 1'b0, "R9 fetch sets referenced");
        issue(2'd1, 20'h02820, 4'd7, 7'h00, 1'b0, "R6 store mismatch");
        issue(2'd3, 20'h02800, 4'd0, 7'h00, 1'b0, "R10 store viol leaves entry");
        issue(2'd1, 20'h02FFF, 4'd3, 7'h00, 1'b0, "R9 store match");
        issue(2'd3, 20'h02800, 4'd0, 7'h00, 1'b0, "R9 store sets both");

        issue(2'd2, 20'h04800, 4'd1, 7'h34, 1'b0, "R4 setkey blk9 fp");
        issue(2'd0, 20'h04800, 4'd2, 7'h00, 1'b0, "R7 fetch protected mismatch");
        issue(2'd3, 20'h04800, 4'd0, 7'h00, 1'b0, "R10 fetch viol leaves entry");
        issue(2'd0, 20'h04804, 4'd0, 7'h00, 1'b0, "R8 master fetch");
        issue(2'd0, 20'h04808, 4'd6, 7'h00, 1'b0, "R7 fetch protected match");
        issue(2'd1, 20'h04900, 4'd0, 7'h00, 1'b1, "R8 master store");
        issue(2'd3, 20'h04800, 4'd0, 7'h00, 1'b0, "R9 blk9 after store");

        issue(2'd2, 20'h00000, 4'd0, 7'h50, 1'b0, "R4 setkey blk0 key10");
        issue(2'd1, 20'h00100, 4'd0, 7'h00, 1'b1, "R11 low store key0");
        issue(2'd1, 20'h001FF, 4'd0, 7'h00, 1'b1, "R11 store at 511");
        issue(2'd3, 20'h00000, 4'd0, 7'h00, 1'b0, "R10 low viol leaves entry");
        issue(2'd1, 20'h00200, 4'd0, 7'h00, 1'b1, "R11 store at 512");
        issue(2'd2, 20'h00000, 4'd0, 7'h50, 1'b0, "R4 setkey clears flags");
        issue(2'd3, 20'h00000, 4'd0, 7'h00, 1'b0, "R4 flags cleared");
        issue(2'd1, 20'h00100, 4'd0, 7'h00, 1'b0, "R11 lap off store low");
        issue(2'd0, 20'h00010, 4'd3, 7'h00, 1'b1, "R11 fetch low unaffected");

        issue(2'd2, 20'hFFFFF, 4'd0, 7'h7C, 1'b0, "R12 setkey last blk");
        issue(2'd1, 20'hFF800, 4'd15, 7'h00, 1'b0, "R12 store last blk");
        issue(2'd3, 20'hFFFFF, 4'd0, 7'h00, 1'b0, "R12 last blk flags");
        issue(2'd3, 20'hFF7FF, 4'd0, 7'h00, 1'b0, "R12 neighbour untouched");

        repeat (6) @(negedge clk);
        check("R2 all responses seen", 7'(sb.size()), 7'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule